// File: doc/BRIEF.md
# Fixed-Priority Event Readout Arbiter

This block gathers pending events from fifteen feature channels and presents them, one at a time, on a single shared output bus. Each channel raises a one-cycle event strobe whenever it captures a new interval and energy measurement. The strobe sets that channel's request latch. A priority encoder chooses among the pending requests, always favouring the channel with the highest index, which is the channel with the highest centre frequency. The chosen channel's binary address is stored in an address register, and that register steers the output multiplexer that places the channel's interval and energy values on the bus next to the address.

A host takes each event with an acknowledge pulse. The rising edge of the pulse clears only the request latch of the channel being served. Its falling edge loads the encoder's current winner into the address register. While no event is in service, the register follows the encoder so that a fresh request reaches the bus without an acknowledge. A mode input bypasses the address register and lets the host select any channel directly. In that mode the acknowledge clears the selected channel.

Top module: `evt_readout_arbiter`

## Requirements
- R1: After reset every request latch is clear, `valid_o` is 0 and `addr_o` is 0.
- R2: An `evt_i[c]` strobe sampled at a clock edge sets request c at that edge. If no event is in service, `addr_o` shows c and `valid_o` is 1 after the following edge.
- R3: When several requests are pending at a load, the channel with the highest index is loaded. Channel NCH-1 has the top priority.
- R4: While the addressed request is set and no acknowledge is in progress, the stored address does not change, even when a request of higher priority arrives.
- R5: At the rising edge of `ack_i`, only the request of the currently addressed channel is cleared. All other requests stay pending.
- R6: At the falling edge of `ack_i`, the address register loads the highest-index pending request.
- R7: No request is lost. A strobe on another channel in the same cycle as a clear survives. A strobe on the served channel while `ack_i` is high, after its rising edge, re-arms that channel.
- R8: When `ext_mode_i` is 1, `addr_o` equals `ext_addr_i`, and the bus shows that channel's data. `valid_o` equals that channel's request, and the acknowledge clears that channel.
- R9: An external address of NCH or above gives `valid_o` = 0 and all-zero interval and energy outputs.
- R10: Whenever `valid_o` is 1, `ivl_o` and `nrg_o` equal the interval and energy inputs of the channel at `addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NCH | One-cycle event strobe per channel; bit c is channel c |
| ivl_i | input | NCH*IW | Held interval values; channel c at bits [c*IW +: IW] |
| nrg_i | input | NCH*EW | Held energy values; channel c at bits [c*EW +: EW] |
| ack_i | input | 1 | Acknowledge pulse from the host, synchronous to clk |
| ext_mode_i | input | 1 | 1 selects the external address |
| ext_addr_i | input | AW | External channel address |
| valid_o | output | 1 | The addressed channel has a pending event |
| addr_o | output | AW | Address of the channel on the bus |
| ivl_o | output | IW | Interval of the addressed channel |
| nrg_o | output | EW | Energy of the addressed channel |

## Verification
A wrong priority decision shows at the ports on the first load that follows it: events come out of order, one cycle after the acknowledge falls or after the bus goes idle. A request latch that clears the wrong channel or drops a strobe shows as a missing or repeated event when the scoreboard drains its queue, no more than one handshake later. An address register that moves during service changes `addr_o` and the data while `valid_o` is high, and this is visible on the next cycle. The external mode is checked by sweeping the host address across pending, cleared and out-of-range channels.

// File: rtl/evt_readout_arbiter.sv
module evt_readout_arbiter #(
  parameter int NCH = 15,
  parameter int IW  = 8,
  parameter int EW  = 10,
  parameter int AW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    evt_i,
  input  logic [NCH*IW-1:0] ivl_i,
  input  logic [NCH*EW-1:0] nrg_i,
  input  logic              ack_i,
  input  logic              ext_mode_i,
  input  logic [AW-1:0]     ext_addr_i,
  output logic              valid_o,
  output logic [AW-1:0]     addr_o,
  output logic [IW-1:0]     ivl_o,
  output logic [EW-1:0]     nrg_o
);
  localparam int SPAN = 2**AW;

  logic [NCH-1:0]  req_q;
  logic [SPAN-1:0] req_pad;
  logic [SPAN-1:0] clr_pad;
  logic [AW-1:0]   addr_q;
  logic [AW-1:0]   addr_sel;
  logic [AW-1:0]   top;
  logic            ack_q;
  logic            ack_rise;
  logic            load;

  always_comb begin
    req_pad = '0;
    req_pad[NCH-1:0] = req_q;
  end

  always_comb begin
    top = '0;
    for (int c = 0; c < NCH; c++)
      if (req_q[c]) top = AW'(c);
  end

  assign addr_sel = ext_mode_i ? ext_addr_i : addr_q;
  assign ack_rise = ack_i & ~ack_q;
  assign load     = ~ack_i & (ack_q | ~req_pad[addr_q]);
  assign clr_pad  = ack_rise ? ({{(SPAN-1){1'b0}}, 1'b1} << addr_sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      addr_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      req_q <= (req_q & ~clr_pad[NCH-1:0]) | evt_i;
      ack_q <= ack_i;
      if (load) addr_q <= top;
    end
  end

  always_comb begin
    ivl_o = '0;
    nrg_o = '0;
    if (int'(addr_sel) < NCH) begin
      ivl_o = ivl_i[int'(addr_sel)*IW +: IW];
      nrg_o = nrg_i[int'(addr_sel)*EW +: EW];
    end
  end

  assign valid_o = req_pad[addr_sel];
  assign addr_o  = addr_sel;
endmodule

module evt_readout_checker #(
  parameter int NCH = 15,
  parameter int AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] evt_i,
  input logic           ack_i,
  input logic           ext_mode_i,
  input logic [AW-1:0]  ext_addr_i,
  input logic           valid_o,
  input logic [NCH-1:0] req_q,
  input logic [AW-1:0]  addr_q,
  input logic           ack_q
);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((req_q & $past(evt_i)) == $past(evt_i)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ack_i && !ack_q && !ext_mode_i) |=> $stable(addr_q));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !ack_q && !ext_mode_i && !evt_i[addr_q]) |=> !req_q[$past(addr_q)]);

  assert_fall_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !ack_i && (|req_q)) |=> (($past(req_q) >> addr_q) == NCH'(1)));

  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode_i && int'(ext_addr_i) >= NCH) |-> !valid_o);
endmodule

bind evt_readout_arbiter evt_readout_checker #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/test_evt_readout_arbiter.sv
`timescale 1ns/1ps
module test_evt_readout_arbiter;
  localparam int NCH = 15, IW = 8, EW = 10, AW = 4;
  localparam realtime CYC = 4.0;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] evt = '0;
  logic [NCH*IW-1:0] ivl;
  logic [NCH*EW-1:0] nrg;
  logic ack = 0, ext_mode = 0;
  logic [AW-1:0] ext_addr = '0;
  logic valid;
  logic [AW-1:0] addr;
  logic [IW-1:0] ivl_o;
  logic [EW-1:0] nrg_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int exp_q[$];

  always #(CYC/2) clk = ~clk;

  evt_readout_arbiter #(.NCH(NCH), .IW(IW), .EW(EW), .AW(AW)) i_evt_readout_arbiter (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ivl_i(ivl), .nrg_i(nrg),
    .ack_i(ack), .ext_mode_i(ext_mode), .ext_addr_i(ext_addr),
    .valid_o(valid), .addr_o(addr), .ivl_o(ivl_o), .nrg_o(nrg_o));

  function automatic int ivl_of(int c); return (c*17 + 1) % 256; endfunction
  function automatic int nrg_of(int c); return (c*37 + 100) % 1024; endfunction

  task automatic check(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic fire(logic [NCH-1:0] m);
    evt = m; cyc(1); evt = '0;
  endtask

  task automatic ack_pulse();
    ack = 1; cyc(2); ack = 0; cyc(1);
  endtask

  task automatic expect_evt(int c); exp_q.push_back(c); endtask

  task automatic wait_valid();
    for (int i = 0; i < 20 && !valid; i++) cyc(1);
  endtask

  task automatic serve_next(string rq);
    int c;
    c = exp_q.pop_front();
    wait_valid();
    check(valid === 1'b1, rq, int'(valid), 1);
    check(int'(addr) == c, rq, int'(addr), c);
    check(int'(ivl_o) == ivl_of(c) && int'(nrg_o) == nrg_of(c), "R10", int'(ivl_o), ivl_of(c));
    ack_pulse();
  endtask

  initial begin
    #(CYC*150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      ivl[c*IW +: IW] = IW'(ivl_of(c));
      nrg[c*EW +: EW] = EW'(nrg_of(c));
    end
    cyc(3); rst_n = 1; cyc(2);
    check(valid == 0, "R1 valid", int'(valid), 0);
    check(addr == 0, "R1 addr", int'(addr), 0);

    // R2: single event latency
    fire(NCH'(1) << 3);
    check(valid == 0, "R2 early", int'(valid), 0);
    cyc(1);
    check(valid == 1 && addr == 3, "R2 timing", int'(addr), 3);
    expect_evt(3); serve_next("R2");
    cyc(2);
    check(valid == 0, "R5 idle after ack", int'(valid), 0);

    // R3/R6: priority order
    fire((NCH'(1) << 2) | (NCH'(1) << 9) | (NCH'(1) << 5));
    expect_evt(9); expect_evt(5); expect_evt(2);
    serve_next("R3"); serve_next("R6"); serve_next("R5");
    cyc(2);
    check(valid == 0, "R5 drained", int'(valid), 0);

    // R4: no preemption
    fire(NCH'(1) << 4); cyc(1);
    fire(NCH'(1) << 12); cyc(3);
    check(addr == 4 && valid == 1, "R4 hold", int'(addr), 4);
    expect_evt(4); expect_evt(12);
    serve_next("R4"); serve_next("R6");

    // R7: strobe on another channel during clear
    fire(NCH'(1) << 6); wait_valid();
    check(addr == 6, "R7 setup", int'(addr), 6);
    ack = 1; evt = NCH'(1) << 1; cyc(1); evt = '0; cyc(1); ack = 0; cyc(1);
    expect_evt(1); serve_next("R7 other channel");

    // R7: re-arm of served channel during acknowledge
    fire(NCH'(1) << 8); wait_valid();
    ack = 1; cyc(1); evt = NCH'(1) << 8; cyc(1); evt = '0; ack = 0; cyc(1);
    expect_evt(8); serve_next("R7 rearm");
    cyc(2);
    check(valid == 0, "R7 no extra", int'(valid), 0);

    // R8/R9: external address mode
    ext_mode = 1; ext_addr = 7;
    fire((NCH'(1) << 7) | (NCH'(1) << 10));
    check(valid == 1 && addr == 7, "R8 select", int'(addr), 7);
    check(int'(ivl_o) == ivl_of(7) && int'(nrg_o) == nrg_of(7), "R8 data", int'(ivl_o), ivl_of(7));
    ack_pulse();
    check(valid == 0, "R8 ack clears selected", int'(valid), 0);
    ext_addr = 10; cyc(1);
    check(valid == 1 && int'(ivl_o) == ivl_of(10), "R8 other kept", int'(ivl_o), ivl_of(10));
    ext_addr = 15; cyc(1);
    check(valid == 0 && ivl_o == 0 && nrg_o == 0, "R9 out of range", int'(ivl_o), 0);
    ext_addr = 10; cyc(1);
    ack_pulse();
    ext_mode = 0; cyc(3);
    check(valid == 0, "R8 cleared in ext mode", int'(valid), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule